// File: doc/BRIEF.md
# GPIO Edge-Detect Interrupt Unit

This unit watches a vector of GPIO pin levels and turns the transitions it sees into interrupts. The levels arrive already synchronised to the block clock. Each pin can be armed for rising transitions, falling transitions, both, or neither. When an armed transition occurs, a sticky status flag for that pin is set. The flag stays set until software writes a one to it.

Three interrupt lines leave the block. Pins 0 and 1 each own a private line that follows their own status flag. Every other pin feeds a single shared line, which is the OR of all remaining status flags across every bank.

Software reaches the block through a flat register window. The window is organised as 32-pin banks. The last bank may be only partly populated, for example 17 valid pins when the default is 81 pins.

Top module: `gpio_edge_irq`

## Requirements
- R1: After reset, every rising-enable, falling-enable and status bit reads 0, and all three interrupt outputs are low.
- R2: With only the rising enable set for a pin, a level change from 0 to 1 sets its status bit on the clock edge that first samples the new level. A change from 1 to 0 sets nothing.
- R3: With only the falling enable set for a pin, a change from 1 to 0 sets its status bit. A change from 0 to 1 sets nothing.
- R4: With both enables set, either direction of change sets the status bit. With neither set, no change does.
- R5: A status bit stays set until a write with a 1 in its position. Writing 0 leaves the bit untouched, and writing all ones clears every pending bit of that bank.
- R6: If an armed edge and a clearing write reach the same status bit in the same cycle, the bit remains set.
- R7: Writing an enable bit never produces a status bit by itself. Edges that occur while a pin's enables are clear are not recorded later.
- R8: irq_pin0_o is high exactly while the status bit of pin 0 is set, and irq_pin1_o is high exactly while the status bit of pin 1 is set.
- R9: irq_shared_o is the OR of the status bits of pins 2 to NUM_PINS-1 across all banks. The status bits of pins 0 and 1 never drive it.
- R10: Address bits [BANK_AW+1:BANK_AW] select the register kind: 0 is rising enable, 1 is falling enable, 2 is status, and 3 reads 0 and ignores writes. Bits [BANK_AW-1:0] select the bank. Bit i of a word maps to pin 32*bank+i. Enable words read back as written, and bit positions beyond NUM_PINS read 0 and cannot be set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_level_i | input | NUM_PINS | Synchronised pin levels |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | BANK_AW+2 | Register address: {kind, bank} |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data, combinational from reg_addr_i |
| irq_pin0_o | output | 1 | Private interrupt for pin 0 |
| irq_pin1_o | output | 1 | Private interrupt for pin 1 |
| irq_shared_o | output | 1 | Shared interrupt for pins 2 and up |

## Verification
Directed cases toggle single pins under each enable setting: rising only, falling only, both and none. This separates the two polarity paths and shows that a swapped or merged comparison is caught. Further directed cases collide an edge with a clearing write, write zeros and then all ones to a status word, flip enables while a pin sits steady, and edge pins 0, 1 and a high pin in the partial last bank. Together these pick apart the private lines, the shared line and the masking of invalid positions. A seeded random phase then mixes sparse pin toggles with random register writes, so enable changes, clears and edges overlap in combinations the directed cases do not reach.

// File: rtl/gei_pkg.sv
package gei_pkg;
  localparam int unsigned BANK_W = 32;

  typedef enum logic [1:0] {
    K_RISE = 2'd0,
    K_FALL = 2'd1,
    K_STAT = 2'd2,
    K_NONE = 2'd3
  } reg_kind_e;

  // number of populated pins in bank b
  function automatic int unsigned bank_valid(int unsigned npins, int unsigned b);
    if (npins >= (b + 1) * BANK_W) return BANK_W;
    else if (npins > b * BANK_W) return npins - b * BANK_W;
    else return 0;
  endfunction

  function automatic logic [BANK_W-1:0] valid_mask(int unsigned nvalid);
    logic [BANK_W-1:0] m;
    for (int i = 0; i < BANK_W; i++) m[i] = (i < nvalid);
    return m;
  endfunction

  // armed transitions between previous and current level
  function automatic logic [BANK_W-1:0] edge_hits(logic [BANK_W-1:0] cur,
                                                  logic [BANK_W-1:0] prev,
                                                  logic [BANK_W-1:0] ren,
                                                  logic [BANK_W-1:0] fen);
    return (cur & ~prev & ren) | (~cur & prev & fen);
  endfunction

  // new edges dominate a simultaneous clear
  function automatic logic [BANK_W-1:0] status_next(logic [BANK_W-1:0] stat,
                                                    logic [BANK_W-1:0] hits,
                                                    logic [BANK_W-1:0] clr);
    return (stat & ~clr) | hits;
  endfunction
endpackage

// File: rtl/gei_bank.sv
module gei_bank
  import gei_pkg::*;
#(
  parameter int unsigned VALID = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BANK_W-1:0] level_i,
  input  logic              rise_we_i,
  input  logic              fall_we_i,
  input  logic              clr_we_i,
  input  logic [BANK_W-1:0] wdata_i,
  output logic [BANK_W-1:0] rise_en_o,
  output logic [BANK_W-1:0] fall_en_o,
  output logic [BANK_W-1:0] status_o,
  output logic [BANK_W-1:0] hits_o
);
  localparam logic [BANK_W-1:0] VMASK = valid_mask(VALID);

  logic [BANK_W-1:0] prev_q;
  logic [BANK_W-1:0] clr_mask;

  assign hits_o   = edge_hits(level_i & VMASK, prev_q, rise_en_o, fall_en_o);
  assign clr_mask = clr_we_i ? wdata_i : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q    <= '0;
      rise_en_o <= '0;
      fall_en_o <= '0;
      status_o  <= '0;
    end else begin
      prev_q   <= level_i & VMASK;
      status_o <= status_next(status_o, hits_o, clr_mask) & VMASK;
      if (rise_we_i) rise_en_o <= wdata_i & VMASK;
      if (fall_we_i) fall_en_o <= wdata_i & VMASK;
    end
  end

  // R5: a set bit without a clearing write is held
  p_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_we_i) |=> ((status_o & $past(status_o)) == $past(status_o)));

  // R6: a bit hit by an edge is set next cycle, clear or not
  p_edge_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (hits_o != '0) |=> ((status_o & $past(hits_o)) == $past(hits_o)));

  // R7: newly set bits always stem from an armed edge
  p_set_needs_hit_r7: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((status_o & ~$past(status_o) & ~$past(hits_o)) == '0));

  // R10: unpopulated positions stay zero
  p_unused_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ((status_o | rise_en_o | fall_en_o) & ~VMASK) == '0);
endmodule

// File: rtl/gei_irq_combine.sv
module gei_irq_combine #(
  parameter int unsigned NUM_PINS = 81
) (
  input  logic [NUM_PINS-1:0] status_i,
  output logic                irq_pin0_o,
  output logic                irq_pin1_o,
  output logic                irq_shared_o
);
  assign irq_pin0_o   = status_i[0];
  assign irq_pin1_o   = status_i[1];
  assign irq_shared_o = |status_i[NUM_PINS-1:2];
endmodule

// File: rtl/gpio_edge_irq.sv
module gpio_edge_irq
  import gei_pkg::*;
#(
  parameter int unsigned NUM_PINS = 81,
  parameter int unsigned BANK_AW  = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_PINS-1:0] pin_level_i,
  input  logic                reg_we_i,
  input  logic [BANK_AW+1:0]  reg_addr_i,
  input  logic [31:0]         reg_wdata_i,
  output logic [31:0]         reg_rdata_o,
  output logic                irq_pin0_o,
  output logic                irq_pin1_o,
  output logic                irq_shared_o
);
  localparam int unsigned NUM_BANKS = (NUM_PINS + BANK_W - 1) / BANK_W;
  localparam int unsigned PAD_W     = NUM_BANKS * BANK_W;

  reg_kind_e          kind;
  logic [BANK_AW-1:0] bank_sel;
  logic [PAD_W-1:0]   level_pad;
  logic [PAD_W-1:0]   stat_flat;
  logic [PAD_W-1:0]   hit_flat;
  logic [BANK_W-1:0]  rise_w [NUM_BANKS];
  logic [BANK_W-1:0]  fall_w [NUM_BANKS];
  logic [BANK_W-1:0]  stat_w [NUM_BANKS];

  assign kind     = reg_kind_e'(reg_addr_i[BANK_AW+1:BANK_AW]);
  assign bank_sel = reg_addr_i[BANK_AW-1:0];

  always_comb begin
    level_pad = '0;
    level_pad[NUM_PINS-1:0] = pin_level_i;
  end

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic sel;
    assign sel = reg_we_i && (bank_sel == BANK_AW'(b));

    gei_bank #(.VALID(bank_valid(NUM_PINS, b))) u_bank (
      .clk       (clk),
      .rst_n     (rst_n),
      .level_i   (level_pad[b*BANK_W +: BANK_W]),
      .rise_we_i (sel && kind == K_RISE),
      .fall_we_i (sel && kind == K_FALL),
      .clr_we_i  (sel && kind == K_STAT),
      .wdata_i   (reg_wdata_i),
      .rise_en_o (rise_w[b]),
      .fall_en_o (fall_w[b]),
      .status_o  (stat_w[b]),
      .hits_o    (hit_flat[b*BANK_W +: BANK_W])
    );
    assign stat_flat[b*BANK_W +: BANK_W] = stat_w[b];
  end

  always_comb begin
    reg_rdata_o = '0;
    for (int b = 0; b < NUM_BANKS; b++) begin
      if (bank_sel == BANK_AW'(b)) begin
        case (kind)
          K_RISE:  reg_rdata_o = rise_w[b];
          K_FALL:  reg_rdata_o = fall_w[b];
          K_STAT:  reg_rdata_o = stat_w[b];
          default: reg_rdata_o = '0;
        endcase
      end
    end
  end

  gei_irq_combine #(.NUM_PINS(NUM_PINS)) u_irq (
    .status_i     (stat_flat[NUM_PINS-1:0]),
    .irq_pin0_o   (irq_pin0_o),
    .irq_pin1_o   (irq_pin1_o),
    .irq_shared_o (irq_shared_o)
  );

  // R8: the private line of pin 0 rises only if pin 0 was armed
  p_pin0_armed_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_pin0_o) |-> $past(rise_w[0][0] | fall_w[0][0]));

  // R9: the shared line rises only from an edge on pins 2 and up
  p_shared_src_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_shared_o) |-> $past(hit_flat[NUM_PINS-1:2] != '0));
endmodule

// File: tb/test_gpio_edge_irq.sv
`timescale 1ns/100ps
module test_gpio_edge_irq;
  localparam int NP = 81;
  localparam int NB = 3;
  localparam int AW = 2;
  localparam int PW = NB * 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NP-1:0] lvl = '0;
  logic          we = 1'b0;
  logic [AW+1:0] addr = '0;
  logic [31:0]   wd = '0;
  logic [31:0]   rd;
  logic          irq0, irq1, irqs;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  logic [PW-1:0] m_rise, m_fall, m_stat, m_prev, vm;

  always #2 clk = ~clk;

  gpio_edge_irq #(.NUM_PINS(NP), .BANK_AW(AW)) i_gpio_edge_irq (
    .clk(clk), .rst_n(rst_n), .pin_level_i(lvl), .reg_we_i(we),
    .reg_addr_i(addr), .reg_wdata_i(wd), .reg_rdata_o(rd),
    .irq_pin0_o(irq0), .irq_pin1_o(irq1), .irq_shared_o(irqs));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [PW-1:0] pad(input logic [NP-1:0] v);
    logic [PW-1:0] p = '0;
    p[NP-1:0] = v;
    return p;
  endfunction

  // one clock: drive at negedge, advance model with the pre-edge state
  task automatic step(input logic [NP-1:0] l, input bit w,
                      input logic [AW+1:0] a, input logic [31:0] d);
    logic [PW-1:0] cur, hits, clr;
    int bk, kd;
    lvl = l; we = w; addr = a; wd = d;
    cur  = pad(l);
    hits = ((cur & ~m_prev & m_rise) | (~cur & m_prev & m_fall)) & vm;
    clr  = '0;
    bk = int'(a[AW-1:0]);
    kd = int'(a[AW+1:AW]);
    @(posedge clk);
    @(negedge clk);
    we = 1'b0;
    if (w && bk < NB) begin
      if (kd == 0) m_rise[bk*32 +: 32] = d & vm[bk*32 +: 32];
      if (kd == 1) m_fall[bk*32 +: 32] = d & vm[bk*32 +: 32];
      if (kd == 2) clr[bk*32 +: 32] = d;
    end
    m_stat = ((m_stat & ~clr) | hits) & vm;
    m_prev = cur;
  endtask

  task automatic idle(input logic [NP-1:0] l);
    step(l, 1'b0, '0, '0);
  endtask

  task automatic wr(input int kd, input int bk, input logic [31:0] d);
    step(lvl, 1'b1, {2'(kd), AW'(bk)}, d);
  endtask

  function automatic logic [31:0] mword(input int kd, input int bk);
    if (bk >= NB) return '0;
    case (kd)
      0: return m_rise[bk*32 +: 32];
      1: return m_fall[bk*32 +: 32];
      2: return m_stat[bk*32 +: 32];
      default: return '0;
    endcase
  endfunction

  // compare all register words and interrupt lines against the model
  task automatic cmp_all(input string tag);
    for (int k = 0; k < 4; k++) begin
      for (int b = 0; b < 4; b++) begin
        addr = {2'(k), AW'(b)};
        #0.1;
        chk(tag, rd, mword(k, b));
      end
    end
    chk({tag, " irq0"}, {31'd0, irq0}, {31'd0, m_stat[0]});
    chk({tag, " irq1"}, {31'd0, irq1}, {31'd0, m_stat[1]});
    chk({tag, " shared"}, {31'd0, irqs}, {31'd0, |m_stat[NP-1:2]});
  endtask

  function automatic logic [NP-1:0] bitv(input int i);
    logic [NP-1:0] v = '0;
    v[i] = 1'b1;
    return v;
  endfunction

  initial begin
    #(4 * 150000);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    for (int i = 0; i < PW; i++) vm[i] = (i < NP);
    m_rise = '0; m_fall = '0; m_stat = '0; m_prev = '0;
    r = $urandom(32'd17);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    cmp_all("R1 reset");

    // R10: map, readback, partial bank, kind 3
    wr(0, 2, 32'hffff_ffff); cmp_all("R10 partial bank");
    wr(1, 1, 32'h1234_5678); cmp_all("R10 readback");
    wr(3, 0, 32'hffff_ffff); cmp_all("R10 kind3 ignored");
    wr(0, 2, 0); wr(1, 1, 0); cmp_all("R10 cleared");

    // R2: rising only on pin 5
    wr(0, 0, 32'h20);
    idle(bitv(5)); cmp_all("R2 rise sets");
    wr(2, 0, 32'h20);
    idle('0); cmp_all("R2 fall ignored");
    // R3: falling only on pin 40
    wr(0, 0, 0); wr(1, 1, 32'h100);
    idle(bitv(40)); cmp_all("R3 rise ignored");
    idle('0); cmp_all("R3 fall sets");
    wr(2, 1, 32'hffff_ffff);
    // R4: both on pin 70, then none
    wr(0, 2, 32'h40); wr(1, 2, 32'h40); wr(1, 1, 0);
    idle(bitv(70)); cmp_all("R4 both rise");
    wr(2, 2, 32'h40);
    idle('0); cmp_all("R4 both fall");
    wr(0, 2, 0); wr(1, 2, 0);
    idle(bitv(70)); idle('0); cmp_all("R4 none");
    // R5: write 0 keeps, all ones clears bank
    wr(0, 0, 32'h0000_00f0);
    idle(lvl | bitv(4) | bitv(7)); cmp_all("R5 set");
    wr(2, 0, 32'h0); cmp_all("R5 zero write kept");
    wr(2, 1, 32'hffff_ffff); cmp_all("R5 other bank untouched");
    wr(2, 0, 32'hffff_ffff); cmp_all("R5 all ones clear");
    // R6: edge and clear collide on pin 6
    step(lvl | bitv(6), 1'b1, {2'd2, AW'(0)}, 32'h40); cmp_all("R6 edge wins");
    wr(2, 0, 32'hffff_ffff);
    // R7: enable toggling with steady level, edges while disabled
    wr(0, 0, 0); idle('0); idle(bitv(9)); idle(bitv(9));
    wr(0, 0, 32'h200); wr(1, 0, 32'h200); cmp_all("R7 enable no edge");
    wr(0, 0, 0); wr(1, 0, 0); cmp_all("R7 disable");
    // R8 / R9: pins 0, 1 and a high pin
    wr(0, 0, 32'h3); idle(bitv(0)); cmp_all("R8 pin0 line");
    idle(bitv(0) | bitv(1)); cmp_all("R8 pin1 line");
    idle('0); cmp_all("R9 shared excludes pins 0 and 1");
    wr(0, 2, 32'h1_0000); idle(bitv(80)); cmp_all("R9 shared from pin 80");
    wr(2, 0, 32'h1); cmp_all("R8 pin0 cleared");
    wr(2, 2, 32'hffff_ffff); cmp_all("R9 shared cleared");
    wr(2, 0, 32'hffff_ffff);

    // random phase
    for (int s = 0; s < 600; s++) begin
      logic [NP-1:0] tg;
      logic [AW+1:0] ra;
      tg = '0;
      for (int j = 0; j < 3; j++) if ($urandom % 2 == 0) tg[$urandom % NP] = 1'b1;
      ra = AW'($urandom);
      ra[AW+1:AW] = 2'($urandom);
      if ($urandom % 4 == 0)
        step(lvl ^ tg, 1'b1, ra, $urandom);
      else
        idle(lvl ^ tg);
      cmp_all("R2-R9 random");
    end

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule